// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block sits inside a small SDRAM controller and handles putting the memory into self-refresh and bringing it back out. Software sets a request bit with a one-cycle strobe. When no SDRAM access is in progress, the block lowers the clock-enable pin (CKE) and issues a self-refresh entry command. While the memory refreshes itself, the block holds off the controller's periodic refresh logic.

An internal read or write to SDRAM space wakes the memory, but only once a minimum residency of tRAS cycles has passed. The block raises CKE and waits tRAS+tRP cycles. It then issues a mandatory auto-refresh and waits another tRAS+tRP cycles. Finally it issues the activate for the waiting transfer, together with a one-cycle handoff pulse.

A separate software bit gates the SDRAM clock, and the block passes it straight to the clock-enable output. If an access arrives during self-refresh while that bit is cleared, the access is refused with a bus error and the memory stays in self-refresh. Both timing counts are programmable, and a value of zero is treated as one.

Top module: `sdram_selfrefresh_seq`

## Requirements
- R1: After reset, cke is 1, cmdOut is NOP (0), refreshHold, busErr, actGo and srReqBit are 0.
- R2: A one-cycle srReqSet sets srReqBit. With srReqBit set and accBusy low, cke falls and cmdOut shows self-refresh entry (1) for exactly the first cycle of cke low. While accBusy is high, cke stays at 1.
- R3: refreshHold is 1 from the self-refresh entry cycle through the activate cycle inclusive, and 0 again in the cycle after the activate.
- R4: Once cke falls, it stays low for at least tRAS cycles. An access strobed in the k-th cycle of cke low (k from 1) gives exactly max(tRAS, k+1) cycles of cke low.
- R5: With no access, the device stays in self-refresh indefinitely, with cke 0 and cmdOut NOP.
- R6: On exit, cke is 1 with cmdOut NOP for exactly tRAS+tRP cycles, counted from the first cycle of cke high. Auto-refresh (cmdOut 2) follows in the next cycle.
- R7: After the auto-refresh cycle, cmdOut is NOP for exactly tRAS+tRP cycles. Activate (cmdOut 3) follows, with actGo high for that single cycle only.
- R8: An accReq during self-refresh while clkEnBit is 0 gives busErr high in the next cycle, for one cycle. cke stays 0 and no exit starts.
- R9: srReqBit reads 0 from the first cycle of cke high on exit.
- R10: sdClkEn equals clkEnBit at all times, including during self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| srReqSet | input | 1 | One-cycle strobe that writes 1 to the self-refresh request bit |
| clkEnBit | input | 1 | Software SDRAM clock-enable bit |
| accReq | input | 1 | One-cycle strobe: internal read or write to SDRAM space |
| accBusy | input | 1 | An SDRAM access is in progress elsewhere in the controller |
| tRasCfg | input | CNT_W | Programmed tRAS count in cycles |
| tRpCfg | input | CNT_W | Programmed tRP count in cycles |
| cke | output | 1 | SDRAM clock-enable pin |
| cmdOut | output | 2 | Command bus: 0 NOP, 1 self-refresh entry, 2 auto-refresh, 3 activate |
| refreshHold | output | 1 | Holds off periodic auto-refresh |
| busErr | output | 1 | One-cycle bus error for a refused access |
| actGo | output | 1 | One-cycle pulse with the activate of the waking transfer |
| srReqBit | output | 1 | Readable state of the self-refresh request bit |
| sdClkEn | output | 1 | SDRAM clock enable, passed from clkEnBit |

## Verification
The bench sends wake-up accesses before the minimum residency has passed. A design that woke on the request alone would show a cke-low span shorter than tRAS. The two post-exit waits are counted cycle by cycle across random tRAS/tRP pairs, including the value 1. This catches an off-by-one counter reload, as well as a design that uses tRP or tRAS alone instead of their sum. An access made with the clock bit cleared must raise a single busErr and leave cke low. A design that treated it as a wake-up would raise cke. An entry request held up by a busy access must not lower cke until the access ends.

// File: rtl/sdram_selfrefresh_seq_pkg.sv
package sdram_selfrefresh_seq_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_ENTER,
    ST_HOLD,
    ST_XSR,
    ST_AREF,
    ST_RFC,
    ST_ACT
  } seqState_t;

  localparam logic [1:0] CMD_NOP  = 2'd0;
  localparam logic [1:0] CMD_SREF = 2'd1;
  localparam logic [1:0] CMD_AREF = 2'd2;
  localparam logic [1:0] CMD_ACT  = 2'd3;

  typedef struct packed {
    logic loadRas;   // reload counter with tRAS-1
    logic loadWin;   // reload counter with tRAS+tRP-1
    logic countDn;   // decrement toward zero
    logic srWindow;  // device currently in self-refresh
    logic exitGo;    // exit accepted this cycle
    logic actDone;   // activate issued this cycle
  } seqStrobe_t;

endpackage

// File: rtl/sdram_selfrefresh_seq_dp.sv
module sdram_selfrefresh_seq_dp
  import sdram_selfrefresh_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             srReqSet,
  input  logic             clkEnBit,
  input  logic             accReq,
  input  logic [CNT_W-1:0] tRasCfg,
  input  logic [CNT_W-1:0] tRpCfg,
  output logic             cntZero,
  output logic             pending,
  output logic             reqBit,
  output logic             busErr
);

  localparam int WIN_W = CNT_W + 1;

  logic [CNT_W-1:0] rasEff;
  logic [CNT_W-1:0] rpEff;
  logic [WIN_W-1:0] winLen;
  logic [WIN_W-1:0] cnt;

  // zero-valued timing fields behave as one cycle
  always_comb begin
    rasEff = (tRasCfg == '0) ? CNT_W'(1) : tRasCfg;
    rpEff  = (tRpCfg  == '0) ? CNT_W'(1) : tRpCfg;
    winLen = {1'b0, rasEff} + {1'b0, rpEff};
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.loadRas) begin
      cnt <= {1'b0, rasEff} - WIN_W'(1);
    end else if (strobe.loadWin) begin
      cnt <= winLen - WIN_W'(1);
    end else if (strobe.countDn && !cntZero) begin
      cnt <= cnt - WIN_W'(1);
    end
  end

  // wake-up capture: only a legal access inside self-refresh counts
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobe.actDone) begin
      pending <= 1'b0;
    end else if (accReq && strobe.srWindow && clkEnBit) begin
      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBit <= 1'b0;
    end else if (strobe.exitGo) begin
      reqBit <= 1'b0;
    end else if (srReqSet) begin
      reqBit <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busErr <= 1'b0;
    end else begin
      busErr <= accReq && strobe.srWindow && !clkEnBit;
    end
  end

endmodule

// File: rtl/sdram_selfrefresh_seq_ctrl.sv
module sdram_selfrefresh_seq_ctrl
  import sdram_selfrefresh_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqBit,
  input  logic       accBusy,
  input  logic       cntZero,
  input  logic       pending,
  output seqStrobe_t strobe,
  output logic       cke,
  output logic [1:0] cmdOut,
  output logic       refreshHold,
  output logic       actGo
);

  seqState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_NORMAL;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    unique case (state)
      ST_NORMAL: begin
        if (reqBit && !accBusy) begin
          stateNxt       = ST_ENTER;
          strobe.loadRas = 1'b1;
        end
      end
      ST_ENTER, ST_HOLD: begin
        strobe.srWindow = 1'b1;
        strobe.countDn  = 1'b1;
        if (cntZero && pending) begin
          stateNxt       = ST_XSR;
          strobe.loadWin = 1'b1;
          strobe.exitGo  = 1'b1;
        end else begin
          stateNxt = ST_HOLD;
        end
      end
      ST_XSR: begin
        strobe.countDn = 1'b1;
        if (cntZero) stateNxt = ST_AREF;
      end
      ST_AREF: begin
        strobe.loadWin = 1'b1;
        stateNxt       = ST_RFC;
      end
      ST_RFC: begin
        strobe.countDn = 1'b1;
        if (cntZero) stateNxt = ST_ACT;
      end
      ST_ACT: begin
        strobe.actDone = 1'b1;
        stateNxt       = ST_NORMAL;
      end
      default: stateNxt = ST_NORMAL;
    endcase
  end

  always_comb begin
    cke         = !(state == ST_ENTER || state == ST_HOLD);
    refreshHold = (state != ST_NORMAL);
    actGo       = (state == ST_ACT);
    unique case (state)
      ST_ENTER: cmdOut = CMD_SREF;
      ST_AREF:  cmdOut = CMD_AREF;
      ST_ACT:   cmdOut = CMD_ACT;
      default:  cmdOut = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdram_selfrefresh_seq.sv
module sdram_selfrefresh_seq
  import sdram_selfrefresh_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srReqSet,
  input  logic             clkEnBit,
  input  logic             accReq,
  input  logic             accBusy,
  input  logic [CNT_W-1:0] tRasCfg,
  input  logic [CNT_W-1:0] tRpCfg,
  output logic             cke,
  output logic [1:0]       cmdOut,
  output logic             refreshHold,
  output logic             busErr,
  output logic             actGo,
  output logic             srReqBit,
  output logic             sdClkEn
);

  seqStrobe_t strobe;
  logic       cntZero;
  logic       pending;

  sdram_selfrefresh_seq_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqBit      (srReqBit),
    .accBusy     (accBusy),
    .cntZero     (cntZero),
    .pending     (pending),
    .strobe      (strobe),
    .cke         (cke),
    .cmdOut      (cmdOut),
    .refreshHold (refreshHold),
    .actGo       (actGo)
  );

  sdram_selfrefresh_seq_dp #(.CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .srReqSet (srReqSet),
    .clkEnBit (clkEnBit),
    .accReq   (accReq),
    .tRasCfg  (tRasCfg),
    .tRpCfg   (tRpCfg),
    .cntZero  (cntZero),
    .pending  (pending),
    .reqBit   (srReqBit),
    .busErr   (busErr)
  );

  // the clock is never stopped by the sequencer itself
  assign sdClkEn = clkEnBit;

endmodule

// File: rtl/sdram_selfrefresh_seq_chk.sv
module sdram_selfrefresh_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       accBusy,
  input logic       clkEnBit,
  input logic       cke,
  input logic [1:0] cmdOut,
  input logic       refreshHold,
  input logic       busErr,
  input logic       actGo,
  input logic       srReqBit,
  input logic       sdClkEn
);

  p_fall_sref_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> cmdOut == 2'd1);

  p_fall_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> $past(!accBusy));

  p_low_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> refreshHold);

  p_rise_nop_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> cmdOut == 2'd0);

  p_aref_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdOut == 2'd2 |-> cke && refreshHold);

  p_act_cmd_r7: assert property (@(posedge clk) disable iff (!rstN)
    actGo |-> cmdOut == 2'd3);

  p_act_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    actGo |=> !actGo && !refreshHold);

  p_err_stays_r8: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(!cke));

  p_req_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> !srReqBit);

  p_clk_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    sdClkEn == clkEnBit);

endmodule

bind sdram_selfrefresh_seq sdram_selfrefresh_seq_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .accBusy     (accBusy),
  .clkEnBit    (clkEnBit),
  .cke         (cke),
  .cmdOut      (cmdOut),
  .refreshHold (refreshHold),
  .busErr      (busErr),
  .actGo       (actGo),
  .srReqBit    (srReqBit),
  .sdClkEn     (sdClkEn)
);

// File: tb/sdram_selfrefresh_seq_tb_top.sv
module sdram_selfrefresh_seq_tb_top;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN;
  logic             srReqSet, clkEnBit, accReq, accBusy;
  logic [CNT_W-1:0] tRasCfg, tRpCfg;
  logic             cke, refreshHold, busErr, actGo, srReqBit, sdClkEn;
  logic [1:0]       cmdOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sdram_selfrefresh_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .srReqSet(srReqSet), .clkEnBit(clkEnBit),
    .accReq(accReq), .accBusy(accBusy), .tRasCfg(tRasCfg), .tRpCfg(tRpCfg),
    .cke(cke), .cmdOut(cmdOut), .refreshHold(refreshHold), .busErr(busErr),
    .actGo(actGo), .srReqBit(srReqBit), .sdClkEn(sdClkEn)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expLow(input int ras, input int k);
    int r;
    r = (ras < 1) ? 1 : ras;
    return (r > k + 1) ? r : k + 1;
  endfunction

  function automatic int expWin(input int ras, input int rp);
    return ((ras < 1) ? 1 : ras) + ((rp < 1) ? 1 : rp);
  endfunction

  // request entry; returns at the negedge of the first cke-low cycle
  task automatic enterSr();
    @(negedge clk) srReqSet = 1'b1;
    @(negedge clk) srReqSet = 1'b0;
    chk(srReqBit == 1'b1, "R2 request bit set", int'(srReqBit), 1);
    for (int i = 0; i < 6; i++) begin
      if (!cke) break;
      @(negedge clk);
    end
    chk(cke == 1'b0, "R2 cke fell", int'(cke), 0);
    chk(cmdOut == 2'd1, "R2 entry command", int'(cmdOut), 1);
    chk(refreshHold == 1'b1, "R3 hold in self-refresh", int'(refreshHold), 1);
  endtask

  // wake with an access in the k-th low cycle (1-based, counted from lowSoFar)
  task automatic runExit(input int ras, input int rp, input int k, input bit chkLow);
    int low, xsr, rfc;
    low = 1;
    for (int n = 1; n < 400; n++) begin
      accReq = (n == k);
      @(negedge clk);
      if (cke) break;
      low++;
    end
    accReq = 1'b0;
    if (chkLow) chk(low == expLow(ras, k), "R4 low residency", low, expLow(ras, k));
    chk(srReqBit == 1'b0, "R9 request bit cleared", int'(srReqBit), 0);
    chk(cmdOut == 2'd0 && refreshHold, "R6 first high cycle nop+hold", int'(cmdOut), 0);
    xsr = 1;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if (cmdOut != 2'd0 || !cke) break;
      xsr++;
    end
    chk(cmdOut == 2'd2, "R6 auto-refresh issued", int'(cmdOut), 2);
    chk(xsr == expWin(ras, rp), "R6 exit wait length", xsr, expWin(ras, rp));
    rfc = 0;
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      if (cmdOut != 2'd0) break;
      rfc++;
    end
    chk(cmdOut == 2'd3 && actGo, "R7 activate with pulse", int'(cmdOut), 3);
    chk(rfc == expWin(ras, rp), "R7 refresh wait length", rfc, expWin(ras, rp));
    chk(refreshHold == 1'b1, "R3 hold through activate", int'(refreshHold), 1);
    @(negedge clk);
    chk(!actGo && !refreshHold && cke && cmdOut == 2'd0, "R7 R3 back to normal",
        int'(actGo) + int'(refreshHold), 0);
  endtask

  initial begin
    int ras, rp, k;
    void'($urandom(32'd4711));
    rstN = 1'b0; srReqSet = 1'b0; clkEnBit = 1'b1; accReq = 1'b0; accBusy = 1'b0;
    tRasCfg = 8'd3; tRpCfg = 8'd2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cke == 1'b1, "R1 cke", int'(cke), 1);
    chk(cmdOut == 2'd0, "R1 cmd", int'(cmdOut), 0);
    chk(!refreshHold && !busErr && !actGo && !srReqBit, "R1 flags",
        int'(refreshHold) + int'(busErr) + int'(actGo) + int'(srReqBit), 0);
    // R10 clock bit passthrough in normal mode
    clkEnBit = 1'b0; #1;
    chk(sdClkEn == 1'b0, "R10 follow low", int'(sdClkEn), 0);
    clkEnBit = 1'b1; #1;
    chk(sdClkEn == 1'b1, "R10 follow high", int'(sdClkEn), 1);

    // R2 entry held off by a busy access
    accBusy = 1'b1;
    @(negedge clk) srReqSet = 1'b1;
    @(negedge clk) srReqSet = 1'b0;
    repeat (8) @(negedge clk);
    chk(cke == 1'b1, "R2 wait while busy", int'(cke), 1);
    accBusy = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!cke) break;
    end
    chk(cke == 1'b0 && cmdOut == 2'd1, "R2 entry after busy", int'(cke), 0);
    runExit(3, 2, 1, 1'b1);

    // R5 indefinite residency, R8 refused access, R10 during self-refresh
    tRasCfg = 8'd2; tRpCfg = 8'd4;
    enterSr();
    repeat (50) @(negedge clk);
    chk(cke == 1'b0 && cmdOut == 2'd0, "R5 stays in self-refresh", int'(cke), 0);
    clkEnBit = 1'b0;
    #1 chk(sdClkEn == 1'b0, "R10 gated in self-refresh", int'(sdClkEn), 0);
    accReq = 1'b1;
    @(negedge clk) accReq = 1'b0;
    chk(busErr == 1'b1, "R8 bus error", int'(busErr), 1);
    chk(cke == 1'b0, "R8 still low", int'(cke), 0);
    @(negedge clk);
    chk(busErr == 1'b0, "R8 single pulse", int'(busErr), 0);
    repeat (12) @(negedge clk);
    chk(cke == 1'b0 && !refreshHold == 1'b0, "R8 no exit started", int'(cke), 0);
    clkEnBit = 1'b1;
    runExit(2, 4, 1, 1'b0);

    // R4 early access against a long residency
    tRasCfg = 8'd20; tRpCfg = 8'd3;
    enterSr();
    runExit(20, 3, 1, 1'b1);

    // randomized timing and wake-up positions, including the value 1
    for (int it = 0; it < 30; it++) begin
      ras = (it == 0) ? 1 : 1 + int'($urandom_range(0, 9));
      rp  = (it == 0) ? 1 : 1 + int'($urandom_range(0, 9));
      k   = 1 + int'($urandom_range(0, 14));
      tRasCfg = CNT_W'(ras); tRpCfg = CNT_W'(rp);
      repeat (1 + int'($urandom_range(0, 3))) @(negedge clk);
      enterSr();
      runExit(ras, rp, k, 1'b1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule